// File: doc/BRIEF.md
# Deferred Character-LCD Write Bridge

This block connects a fast synchronous CPU bus to a slow character LCD controller. That controller needs a long data setup time and a wide write strobe, so a write cannot finish inside one bus cycle. A CPU write is taken into a holding register in a single cycle. Starting on the next cycle, a small sequencer replays the held byte to the panel. It first drives the register-select, read/write and data lines. It then holds the enable strobe high for a number of ticks computed from the clock period. Finally it keeps the lines steady for a short hold time.

When no write is in flight, the bridge never leaves the LCD bus floating. It runs a continuous loop of busy-flag reads and publishes the most recent result on a registered status output, which the CPU can poll. While a replay is outstanding, a ready output is held low. The CPU must then keep its write request asserted until ready returns. Reading display memory back through the bridge is not supported.

All timing follows from parameters: the clock period in ns and the minimum panel times in ns. Tick counts are rounded up.

Top module: `lcd_wr_bridge`

## Requirements
- R1: When `cpu_sel` is high at a rising edge while `cpu_ready` is high, the bridge stores `cpu_wdata` and `cpu_rs`. `cpu_ready` is then low from the next cycle.
- R2: On the cycle after `cpu_ready` falls, the bridge drives the held data and RS onto the panel lines, with `lcd_rw`=0, `lcd_db_oe`=1 and `lcd_en`=0.
- R3: During a write, `lcd_en` stays low for ceil(ADDR_SETUP_NS/CLK_PERIOD_NS) cycles after the write lines appear (4 with default parameters).
- R4: The write strobe `lcd_en` is high for max(ceil(E_HIGH_NS/CLK_PERIOD_NS), ceil(DATA_SETUP_NS/CLK_PERIOD_NS)) cycles (23 by default). `lcd_db_out`, `lcd_rs` and `lcd_rw` do not change while `lcd_en` is high.
- R5: After the strobe falls, the write lines are held for ceil(HOLD_NS/CLK_PERIOD_NS) cycles (2 by default). In the next cycle `lcd_rw` returns to 1 and `cpu_ready` returns to 1 together.
- R6: Outside a write, the bus is in busy-read mode: `lcd_rs`=0, `lcd_rw`=1, `lcd_db_oe`=0. Read strobes repeat with 4 cycles low, 23 high and a 10-cycle gap. At the end of each completed strobe, `lcd_busy` takes bit 7 of `lcd_db_in`, and the other bits have no effect.
- R7: When a write completes, `lcd_busy` reads 1 until the next completed busy-flag read.
- R8: A `cpu_sel` while `cpu_ready` is low is ignored. It changes neither the byte being written nor causes any further write.
- R9: A write captured during a read strobe cuts that strobe short: `lcd_en` is low on the cycle the write lines appear, and `lcd_busy` is not updated from the aborted read.
- R10: Synchronous reset makes `lcd_en`=0, `lcd_rw`=1, `cpu_ready`=1 and `lcd_busy`=1 after the edge, and discards any pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU write request to the LCD address |
| cpu_rs | input | 1 | Register select for the write (0 command, 1 data) |
| cpu_wdata | input | DATA_W | Byte written by the CPU |
| cpu_ready | output | 1 | High when a new write can be accepted |
| lcd_db_in | input | DATA_W | Data lines read back from the panel |
| lcd_db_out | output | DATA_W | Data driven to the panel during writes |
| lcd_db_oe | output | 1 | Output enable for the panel data lines |
| lcd_rs | output | 1 | Panel register select |
| lcd_rw | output | 1 | Panel read (1) / write (0) |
| lcd_en | output | 1 | Panel enable strobe |
| lcd_busy | output | 1 | Last sampled busy flag |

## Verification
The bench measures every strobe phase of a write cycle by cycle. A miscounted timer would show up as a setup, pulse or hold length that is off by one tick. It also issues a write in the first cycle of a read strobe. A bridge that let the read finish would delay the write, and one that sampled the aborted read would publish a stale busy value. Extra requests made during a replay must leave the byte and the write count unchanged. A design that re-captured would either corrupt the data or emit a second strobe. Busy polling uses data patterns in which only bit 7 differs, so reading the wrong bit is caught.

// File: rtl/lcd_br_pkg.sv
package lcd_br_pkg;

  typedef enum logic [2:0] {
    ST_RD_SET,
    ST_RD_HI,
    ST_RD_GAP,
    ST_WR_SET,
    ST_WR_HI,
    ST_WR_HOLD
  } seq_st_t;

  function automatic int ceil_ticks(input int ns, input int period_ns);
    int t;
    t = (ns + period_ns - 1) / period_ns;
    return (t < 1) ? 1 : t;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_tick_timer.sv
module lcd_tick_timer #(
  parameter int CNT_W    = 6,
  parameter int RST_LOAD = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_LOAD);
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_hold_reg.sv
module lcd_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              rs_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              release_i,
  output logic              pending_o,
  output logic              ready_o,
  output logic              hold_rs_o,
  output logic [DATA_W-1:0] hold_data_o
);

  logic pend_q, pend_nx, accept;

  // a request is only taken while the register is empty
  assign accept  = sel_i && !pend_q;
  assign pend_nx = pend_q ? !release_i : sel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      ready_o <= 1'b1;
    end else begin
      pend_q  <= pend_nx;
      ready_o <= !pend_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_rs_o   <= 1'b0;
      hold_data_o <= '0;
    end else if (accept) begin
      hold_rs_o   <= rs_i;
      hold_data_o <= data_i;
    end
  end

  assign pending_o = pend_q;

endmodule

// File: rtl/lcd_busy_flag.sv
module lcd_busy_flag #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              mark_i,
  input  logic [DATA_W-1:0] db_i,
  output logic              busy_o
);

  logic unused_low_bits;
  assign unused_low_bits = ^db_i[DATA_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b1;
    end else if (mark_i) begin
      busy_o <= 1'b1;
    end else if (sample_i) begin
      busy_o <= db_i[DATA_W-1];
    end
  end

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_br_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SET_T  = 4,
  parameter int E_T    = 23,
  parameter int HOLD_T = 2,
  parameter int GAP_T  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pending_i,
  input  logic              hold_rs_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              release_o,
  output logic              sample_o,
  output logic [DATA_W-1:0] db_o,
  output logic              oe_o,
  output logic              rs_o,
  output logic              rw_o,
  output logic              en_o
);

  localparam int MAX_T = max_int(max_int(SET_T, E_T), max_int(HOLD_T, GAP_T));
  localparam int CNT_W = $clog2(MAX_T + 1);

  seq_st_t          st_q, st_nx;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             done;
  logic             nx_is_wr;

  lcd_tick_timer #(
    .CNT_W   (CNT_W),
    .RST_LOAD(SET_T - 1)
  ) timer_i (
    .clk   (clk),
    .rst   (rst),
    .load_i(ld),
    .val_i (ld_val),
    .done_o(done)
  );

  always_comb begin
    st_nx     = st_q;
    ld        = 1'b0;
    ld_val    = '0;
    release_o = 1'b0;
    sample_o  = 1'b0;
    case (st_q)
      ST_RD_SET, ST_RD_HI, ST_RD_GAP: begin
        if (pending_i) begin
          st_nx  = ST_WR_SET;
          ld     = 1'b1;
          ld_val = CNT_W'(SET_T - 1);
        end else if (done) begin
          ld = 1'b1;
          if (st_q == ST_RD_SET) begin
            st_nx  = ST_RD_HI;
            ld_val = CNT_W'(E_T - 1);
          end else if (st_q == ST_RD_HI) begin
            st_nx    = ST_RD_GAP;
            ld_val   = CNT_W'(GAP_T - 1);
            sample_o = 1'b1;
          end else begin
            st_nx  = ST_RD_SET;
            ld_val = CNT_W'(SET_T - 1);
          end
        end
      end
      ST_WR_SET: begin
        if (done) begin
          st_nx  = ST_WR_HI;
          ld     = 1'b1;
          ld_val = CNT_W'(E_T - 1);
        end
      end
      ST_WR_HI: begin
        if (done) begin
          st_nx  = ST_WR_HOLD;
          ld     = 1'b1;
          ld_val = CNT_W'(HOLD_T - 1);
        end
      end
      ST_WR_HOLD: begin
        if (done) begin
          st_nx     = ST_RD_SET;
          ld        = 1'b1;
          ld_val    = CNT_W'(SET_T - 1);
          release_o = 1'b1;
        end
      end
      default: begin
        st_nx  = ST_RD_SET;
        ld     = 1'b1;
        ld_val = CNT_W'(SET_T - 1);
      end
    endcase
  end

  assign nx_is_wr = (st_nx == ST_WR_SET) || (st_nx == ST_WR_HI) ||
                    (st_nx == ST_WR_HOLD);

  // panel lines are registered from the next state so they change with it
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_RD_SET;
      en_o <= 1'b0;
      rw_o <= 1'b1;
      rs_o <= 1'b0;
      oe_o <= 1'b0;
      db_o <= '0;
    end else begin
      st_q <= st_nx;
      en_o <= (st_nx == ST_RD_HI) || (st_nx == ST_WR_HI);
      rw_o <= !nx_is_wr;
      rs_o <= nx_is_wr ? hold_rs_i : 1'b0;
      oe_o <= nx_is_wr;
      db_o <= nx_is_wr ? hold_data_i : '0;
    end
  end

endmodule

// File: rtl/lcd_wr_bridge.sv
module lcd_wr_bridge
  import lcd_br_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int E_HIGH_NS     = 230,
  parameter int DATA_SETUP_NS = 80,
  parameter int ADDR_SETUP_NS = 40,
  parameter int HOLD_NS       = 20,
  parameter int READ_GAP_NS   = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_rs,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  input  logic [DATA_W-1:0] lcd_db_in,
  output logic [DATA_W-1:0] lcd_db_out,
  output logic              lcd_db_oe,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_en,
  output logic              lcd_busy
);

  localparam int SET_T  = ceil_ticks(ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int E_T    = max_int(ceil_ticks(E_HIGH_NS, CLK_PERIOD_NS),
                                  ceil_ticks(DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int HOLD_T = ceil_ticks(HOLD_NS, CLK_PERIOD_NS);
  localparam int GAP_T  = ceil_ticks(READ_GAP_NS, CLK_PERIOD_NS);

  logic              pending, rel, sample;
  logic              hold_rs;
  logic [DATA_W-1:0] hold_data;

  lcd_hold_reg #(.DATA_W(DATA_W)) hold_i (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (cpu_sel),
    .rs_i       (cpu_rs),
    .data_i     (cpu_wdata),
    .release_i  (rel),
    .pending_o  (pending),
    .ready_o    (cpu_ready),
    .hold_rs_o  (hold_rs),
    .hold_data_o(hold_data)
  );

  lcd_seq_ctrl #(
    .DATA_W(DATA_W),
    .SET_T (SET_T),
    .E_T   (E_T),
    .HOLD_T(HOLD_T),
    .GAP_T (GAP_T)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .pending_i  (pending),
    .hold_rs_i  (hold_rs),
    .hold_data_i(hold_data),
    .release_o  (rel),
    .sample_o   (sample),
    .db_o       (lcd_db_out),
    .oe_o       (lcd_db_oe),
    .rs_o       (lcd_rs),
    .rw_o       (lcd_rw),
    .en_o       (lcd_en)
  );

  lcd_busy_flag #(.DATA_W(DATA_W)) busy_i (
    .clk     (clk),
    .rst     (rst),
    .sample_i(sample),
    .mark_i  (rel),
    .db_i    (lcd_db_in),
    .busy_o  (lcd_busy)
  );

endmodule

// File: rtl/lcd_wr_bridge_chk.sv
module lcd_wr_bridge_chk
  import lcd_br_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int E_HIGH_NS     = 230,
  parameter int DATA_SETUP_NS = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_sel,
  input logic              cpu_ready,
  input logic [DATA_W-1:0] lcd_db_out,
  input logic              lcd_db_oe,
  input logic              lcd_rs,
  input logic              lcd_rw,
  input logic              lcd_en,
  input logic              lcd_busy
);

  localparam int E_T = max_int(ceil_ticks(E_HIGH_NS, CLK_PERIOD_NS),
                               ceil_ticks(DATA_SETUP_NS, CLK_PERIOD_NS));

  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else     hi_cnt <= lcd_en ? hi_cnt + 16'd1 : 16'd0;
  end

  p_ready_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_ready) |-> $past(cpu_sel));

  p_write_next_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_ready) |=> (!lcd_rw && lcd_db_oe && !lcd_en));

  p_e_width_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(lcd_en) && !$past(lcd_rw)) |-> (hi_cnt == 16'(E_T)));

  p_lines_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && $past(lcd_en)) |->
      ($stable(lcd_db_out) && $stable(lcd_rs) && $stable(lcd_rw)));

  p_ready_back_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_ready) |-> (lcd_rw && lcd_busy));

  p_read_mode_r6: assert property (@(posedge clk) disable iff (rst)
    lcd_rw |-> (!lcd_db_oe && !lcd_rs));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!lcd_en && lcd_rw && cpu_ready && lcd_busy));

endmodule

bind lcd_wr_bridge lcd_wr_bridge_chk #(
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .E_HIGH_NS    (E_HIGH_NS),
  .DATA_SETUP_NS(DATA_SETUP_NS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_sel   (cpu_sel),
  .cpu_ready (cpu_ready),
  .lcd_db_out(lcd_db_out),
  .lcd_db_oe (lcd_db_oe),
  .lcd_rs    (lcd_rs),
  .lcd_rw    (lcd_rw),
  .lcd_en    (lcd_en),
  .lcd_busy  (lcd_busy)
);

// File: tb/lcd_wr_bridge_tb.sv
module lcd_wr_bridge_tb_top;

  localparam int SET_T = 4, E_T = 23, HOLD_T = 2, LIM = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_sel = 1'b0, cpu_rs = 1'b0;
  logic [7:0] cpu_wdata = '0, lcd_db_in = 8'h80;
  logic       cpu_ready, lcd_db_oe, lcd_rs, lcd_rw, lcd_en, lcd_busy;
  logic [7:0] lcd_db_out;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lcd_wr_bridge dut_i (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_rs(cpu_rs),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .lcd_db_in(lcd_db_in),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_busy(lcd_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic wait_read_end();
    bit prev;
    prev = lcd_en;
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk);
      if (prev && !lcd_en && lcd_rw) return;
      prev = lcd_en;
    end
    check(0, "R6 read strobe end", 0, 1);
  endtask

  // performs one write and measures every phase; junk drives extra requests
  task automatic do_write(input logic [7:0] d, input logic r,
                          input bit mid_read, input bit junk);
    int s, w, h, bad;
    bit prev;
    for (int i = 0; i < LIM && !cpu_ready; i++) @(negedge clk);
    if (mid_read) begin
      prev = lcd_en;
      for (int i = 0; i < LIM; i++) begin
        @(negedge clk);
        if (!prev && lcd_en && lcd_rw) break;
        prev = lcd_en;
      end
    end
    cpu_sel = 1'b1; cpu_rs = r; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0;
    check(cpu_ready == 1'b0, "R1 ready low after capture", cpu_ready, 0);
    if (mid_read)
      check(lcd_busy == 1'b1, "R9 busy before abort", lcd_busy, 1);
    @(negedge clk);
    check(!lcd_rw && lcd_db_oe && !lcd_en, "R2 write lines next cycle",
          {lcd_rw, lcd_db_oe, lcd_en}, 3'b010);
    check(lcd_db_out == d && lcd_rs == r, "R2 held data and rs",
          {lcd_rs, lcd_db_out}, {r, d});
    if (mid_read)
      check(lcd_busy == 1'b1, "R9 aborted read not sampled", lcd_busy, 1);
    s = 0;
    for (int i = 0; i < LIM && !lcd_en; i++) begin s++; @(negedge clk); end
    check(s == SET_T, "R3 setup cycles", s, SET_T);
    w = 0; bad = 0;
    if (junk) begin cpu_sel = 1'b1; cpu_wdata = ~d; cpu_rs = ~r; end
    for (int i = 0; i < LIM && lcd_en; i++) begin
      if (lcd_db_out != d || lcd_rs != r || lcd_rw) bad++;
      w++; @(negedge clk);
    end
    check(w == E_T, "R4 strobe width", w, E_T);
    check(bad == 0, junk ? "R8 data unchanged by extra request" : "R4 lines stable",
          bad, 0);
    cpu_sel = 1'b0;
    h = 0;
    for (int i = 0; i < LIM && !lcd_rw; i++) begin h++; @(negedge clk); end
    check(h == HOLD_T, "R5 hold cycles", h, HOLD_T);
    check(cpu_ready == 1'b1, "R5 ready back with read mode", cpu_ready, 1);
    check(lcd_busy == 1'b1, "R7 busy after write", lcd_busy, 1);
  endtask

  task automatic t_reset();
    check(!lcd_en && lcd_rw && cpu_ready && lcd_busy && !lcd_db_oe,
          "R10 reset state", {lcd_en, lcd_rw, cpu_ready, lcd_busy}, 4'b0111);
  endtask

  task automatic t_busy_poll();
    int hi;
    lcd_db_in = 8'h00; wait_read_end();
    check(lcd_busy == 1'b0, "R6 busy from bit7 low", lcd_busy, 0);
    lcd_db_in = 8'h80; wait_read_end();
    check(lcd_busy == 1'b1, "R6 busy from bit7 high", lcd_busy, 1);
    lcd_db_in = 8'h7F; wait_read_end();
    check(lcd_busy == 1'b0, "R6 low bits ignored", lcd_busy, 0);
    hi = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (lcd_rs || !lcd_rw || lcd_db_oe) hi++;
    end
    check(hi == 0, "R6 idle read mode lines", hi, 0);
  endtask

  task automatic t_stall();
    int extra;
    do_write(8'h22, 1'b1, 1'b0, 1'b1);
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!lcd_rw) extra++;
    end
    check(extra == 0, "R8 no write from ignored request", extra, 0);
  endtask

  task automatic t_mid_reset();
    cpu_sel = 1'b1; cpu_wdata = 8'h3C; cpu_rs = 1'b0;
    @(negedge clk); cpu_sel = 1'b0;
    for (int i = 0; i < LIM && !lcd_en; i++) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(!lcd_en && lcd_rw && cpu_ready && lcd_busy, "R10 reset mid write",
          {lcd_en, lcd_rw, cpu_ready, lcd_busy}, 4'b0111);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!lcd_rw) begin check(0, "R10 pending discarded", 0, 1); break; end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_busy_poll();
    do_write(8'h38, 1'b0, 1'b0, 1'b0);
    do_write(8'hA5, 1'b1, 1'b0, 1'b0);
    lcd_db_in = 8'h00;
    do_write(8'h5A, 1'b1, 1'b1, 1'b0);
    t_stall();
    t_mid_reset();
    finish_run();
  end

  initial begin
    #1_000_000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

endmodule